// File: doc/BRIEF.md
# DRAM Refresh and Wake-up Sequencer

This block keeps an asynchronous page-mode DRAM holding its data. After reset it waits out the power-up pause. It then fires a burst of wake-up cycles that each carry a RAS pulse. From then on it schedules one refresh cycle per refresh interval. Every refresh owed is counted as debt, and the debt is paid back whenever the strobe bus is free. An input selects the refresh style. In CAS-before-RAS style both byte-lane CAS strobes fall ahead of RAS. In row-address style both CAS strobes stay high and a 10-bit row from an internal counter appears on the address pins. Both styles use the same sequencer.

A separate access controller asks for the strobe bus with `acc_req` and owns the bus while `acc_gnt` is high. It keeps ownership until it drops the request. Below the urgency threshold, refresh debt is paid only while the bus is idle. Once the debt reaches the threshold, `urgent` tells the controller to close its page, and refresh wins the next arbitration. If the debt reaches the full row count, the refresh deadline has been missed. The wake-up burst then runs again before any further grant. All timing is given in nanoseconds and is turned into whole clock cycles from the clock-period parameter.

Top module: `dram_refresh_seq`

## Requirements
- R1: From reset and for ceil(WAKE_NS/CLK_NS) cycles after it, `ras_n` is 1, `cas_n` is 2'b11, and `ready` and `acc_gnt` are 0, whatever `acc_req` does.
- R2: After the pause, exactly WAKE_CNT refresh cycles with one RAS low pulse each run before `ready` rises, and no grant is given before `ready` is 1.
- R3: Each RAS low pulse lasts max(ceil(RAS_NS), ceil(CHR_NS)) cycles. Between pulses RAS stays high for at least ceil(RP_NS) cycles.
- R4: With `rf_mode`=0 (CAS-before-RAS), both `cas_n` bits go to 0 ceil(CSR_NS) cycles before RAS falls and return to 1 together with RAS. `row_addr` stays 0.
- R5: With `rf_mode`=1 (row-address refresh), `cas_n` stays 2'b11. `row_addr` carries the internal row counter during the one setup cycle and the RAS low time. The counter advances by one after each such cycle and wraps from 2**ADDR_W-1 to 0.
- R6: The refresh debt grows by one every ceil((WINDOW_NS/2**ADDR_W)/CLK_NS) cycles and saturates at 2**ADDR_W. Each ordinary refresh cycle pays back one. A refresh starts from idle when the debt is non-zero and `acc_req` is 0.
- R7: `urgent` is 1 exactly while the debt is at least URG_TH. While it is 1, an idle arbitration starts a refresh even when `acc_req` is 1.
- R8: `acc_gnt` rises from idle when `acc_req` is 1 and no refresh is chosen, then stays 1 until `acc_req` is 0. While it is 1, RAS and both CAS stay high.
- R9: When the debt reaches 2**ADDR_W, the next arbitration drops `ready` and reruns the WAKE_CNT-cycle burst with no pause, and the debt is cleared when the burst ends.
- R10: Every nanosecond delay rounds up to whole cycles, with a minimum of one. At a 5 ns clock, a 6 ns CAS lead gives 2 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rf_mode | input | 1 | Refresh style, sampled at each cycle start: 0 CAS-before-RAS, 1 row-address |
| acc_req | input | 1 | Access controller asks for or holds the strobe bus |
| acc_gnt | output | 1 | Strobe bus granted to the access controller |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 2 | Byte-lane column strobes, active low (bit 1 upper lane) |
| row_addr | output | ADDR_W | Row address for row-address refresh, 0 otherwise |
| ready | output | 1 | Wake-up complete, normal service allowed |
| urgent | output | 1 | Refresh debt at or above threshold |

## Verification
The hardest case to reach is the missed deadline. For that, the debt must climb to the full row count, which only happens when the access controller holds the bus for a whole refresh window without a break. The bench shrinks the window so one interval is 40 cycles. It then holds `acc_req` high for more than 1024 intervals and afterwards releases it, which sends the block back through the wake-up burst. A second long stretch in row-address style produces more than 1024 refreshes, so the row counter wraps. A pseudo-random stretch of request and style changes covers the arbitration corners in between.

// File: rtl/dram_rf_pkg.sv
package dram_rf_pkg;

    typedef enum logic [2:0] {
        ST_PAUSE,
        ST_BURST,
        ST_IDLE,
        ST_ACC,
        ST_RF
    } seq_st_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_ACT,
        PH_PRE
    } ph_e;

    typedef enum logic {
        RF_CBR = 1'b0,
        RF_ROW = 1'b1
    } rf_mode_e;

    typedef struct packed {
        logic       ras_n;
        logic [1:0] cas_n;
    } strobe_t;

    // nanoseconds to clock cycles, rounded up, never below one
    function automatic int unsigned ns2cyc(int unsigned ns, int unsigned clk_ns);
        int unsigned c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned umax(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rf_debt_ctr.sv
module rf_debt_ctr
    import dram_rf_pkg::*;
#(
    parameter int unsigned T_INT  = 3125,
    parameter int unsigned ROWS   = 1024,
    parameter int unsigned URG_TH = 8,
    parameter int unsigned PW     = 11
) (
    input  logic clk,
    input  logic rst,
    input  logic dec,
    input  logic clear,
    output logic pend_nz,
    output logic urgent,
    output logic missed
);
    localparam int unsigned TW = $clog2(T_INT + 1);

    logic [TW-1:0] tick_cnt;
    logic [PW-1:0] pend;
    logic          tick;
    logic          inc;

    assign tick    = (tick_cnt == TW'(T_INT - 1));
    assign missed  = (pend == PW'(ROWS));
    assign inc     = tick && !missed;
    assign pend_nz = (pend != '0);
    assign urgent  = (pend >= PW'(URG_TH));

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_cnt <= '0;
            pend     <= '0;
        end else begin
            tick_cnt <= tick ? '0 : tick_cnt + 1'b1;
            if (clear)
                pend <= '0;
            else
                pend <= pend + {{(PW-1){1'b0}}, inc} - {{(PW-1){1'b0}}, dec};
        end
    end

    p_pend_bound_r6: assert property (@(posedge clk) disable iff (rst)
        pend <= PW'(ROWS));

    p_dec_has_debt_r6: assert property (@(posedge clk) disable iff (rst)
        (dec && !clear) |-> pend_nz);

endmodule

// File: rtl/rf_cycle_gen.sv
module rf_cycle_gen
    import dram_rf_pkg::*;
#(
    parameter int unsigned ADDR_W   = 10,
    parameter int unsigned T_SU_CBR = 1,
    parameter int unsigned T_ACT    = 10,
    parameter int unsigned T_RP     = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  rf_mode_e          mode,
    output strobe_t           strb,
    output logic [ADDR_W-1:0] addr,
    output logic              busy,
    output logic              done
);
    localparam int unsigned MAXC = umax(umax(T_SU_CBR, T_ACT), T_RP);
    localparam int unsigned CW   = $clog2(MAXC + 1);

    ph_e               ph;
    logic [CW-1:0]     cnt;
    rf_mode_e          mode_q;
    logic [ADDR_W-1:0] row;
    logic              drive;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph     <= PH_IDLE;
            cnt    <= '0;
            mode_q <= RF_CBR;
            row    <= '0;
        end else begin
            unique case (ph)
                PH_IDLE: if (start) begin
                    ph     <= PH_SETUP;
                    mode_q <= mode;
                    cnt    <= (mode == RF_CBR) ? CW'(T_SU_CBR - 1) : '0;
                end
                PH_SETUP: if (cnt == '0) begin
                    ph  <= PH_ACT;
                    cnt <= CW'(T_ACT - 1);
                end else cnt <= cnt - 1'b1;
                PH_ACT: if (cnt == '0) begin
                    ph  <= PH_PRE;
                    cnt <= CW'(T_RP - 1);
                end else cnt <= cnt - 1'b1;
                PH_PRE: if (cnt == '0) begin
                    ph <= PH_IDLE;
                    if (mode_q == RF_ROW) row <= row + 1'b1;
                end else cnt <= cnt - 1'b1;
                default: ph <= PH_IDLE;
            endcase
        end
    end

    assign drive      = (ph == PH_SETUP) || (ph == PH_ACT);
    assign busy       = (ph != PH_IDLE);
    assign done       = (ph == PH_PRE) && (cnt == '0);
    assign strb.ras_n = (ph != PH_ACT);
    assign strb.cas_n = (drive && mode_q == RF_CBR) ? 2'b00 : 2'b11;
    assign addr       = (drive && mode_q == RF_ROW) ? row : '0;

    // run-length counters that exist only for the timing checks
    logic [CW-1:0] low_run;
    logic [CW-1:0] high_run;
    always_ff @(posedge clk) begin
        if (rst) begin
            low_run  <= '0;
            high_run <= CW'(T_RP);
        end else begin
            low_run  <= strb.ras_n ? '0 : ((low_run == CW'(MAXC)) ? low_run : low_run + 1'b1);
            high_run <= !strb.ras_n ? '0 : ((high_run == CW'(MAXC)) ? high_run : high_run + 1'b1);
        end
    end

    p_ras_low_min_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(strb.ras_n) |-> (low_run >= CW'(T_ACT)));

    p_prech_min_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(strb.ras_n) |-> (high_run >= CW'(T_RP)));

    p_cbr_lead_r4: assert property (@(posedge clk) disable iff (rst)
        ($fell(strb.ras_n) && mode_q == RF_CBR) |-> ($past(strb.cas_n) == 2'b00));

    p_row_cas_high_r5: assert property (@(posedge clk) disable iff (rst)
        (!strb.ras_n && mode_q == RF_ROW) |-> (strb.cas_n == 2'b11));

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
    import dram_rf_pkg::*;
#(
    parameter int unsigned CLK_NS    = 5,
    parameter int unsigned ADDR_W    = 10,
    parameter int unsigned WINDOW_NS = 16_000_000,
    parameter int unsigned WAKE_NS   = 200_000,
    parameter int unsigned WAKE_CNT  = 8,
    parameter int unsigned RAS_NS    = 50,
    parameter int unsigned RP_NS     = 30,
    parameter int unsigned CSR_NS    = 5,
    parameter int unsigned CHR_NS    = 8,
    parameter int unsigned URG_TH    = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rf_mode,
    input  logic              acc_req,
    output logic              acc_gnt,
    output logic              ras_n,
    output logic [1:0]        cas_n,
    output logic [ADDR_W-1:0] row_addr,
    output logic              ready,
    output logic              urgent
);
    localparam int unsigned ROWS   = 1 << ADDR_W;
    localparam int unsigned PW     = ADDR_W + 1;
    localparam int unsigned C_RAS  = ns2cyc(RAS_NS, CLK_NS);
    localparam int unsigned C_CHR  = ns2cyc(CHR_NS, CLK_NS);
    localparam int unsigned C_ACT  = umax(C_RAS, C_CHR);
    localparam int unsigned C_RP   = ns2cyc(RP_NS, CLK_NS);
    localparam int unsigned C_CSR  = ns2cyc(CSR_NS, CLK_NS);
    localparam int unsigned C_WAKE = ns2cyc(WAKE_NS, CLK_NS);
    localparam int unsigned C_INT  = ns2cyc(WINDOW_NS / ROWS, CLK_NS);
    localparam int unsigned WW     = $clog2(C_WAKE + 1);
    localparam int unsigned BW     = $clog2(WAKE_CNT + 1);

    seq_st_e       st;
    logic [WW-1:0] wait_cnt;
    logic [BW-1:0] left;
    logic          busy, done, start, clear, dec;
    logic          pend_nz, missed, take_rf;
    strobe_t       strb;

    rf_debt_ctr #(.T_INT(C_INT), .ROWS(ROWS), .URG_TH(URG_TH), .PW(PW)) i_debt (
        .clk(clk), .rst(rst), .dec(dec), .clear(clear),
        .pend_nz(pend_nz), .urgent(urgent), .missed(missed)
    );

    rf_cycle_gen #(.ADDR_W(ADDR_W), .T_SU_CBR(C_CSR), .T_ACT(C_ACT), .T_RP(C_RP)) i_gen (
        .clk(clk), .rst(rst), .start(start), .mode(rf_mode_e'(rf_mode)),
        .strb(strb), .addr(row_addr), .busy(busy), .done(done)
    );

    assign take_rf = urgent || (pend_nz && !acc_req);
    assign start   = ((st == ST_BURST) && !busy && (left != '0))
                  || ((st == ST_IDLE) && !missed && take_rf);
    assign clear   = (st == ST_BURST) && !busy && (left == '0);
    assign dec     = (st == ST_RF) && done;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_PAUSE;
            wait_cnt <= WW'(C_WAKE - 1);
            left     <= '0;
        end else begin
            unique case (st)
                ST_PAUSE: if (wait_cnt == '0) begin
                    st   <= ST_BURST;
                    left <= BW'(WAKE_CNT);
                end else wait_cnt <= wait_cnt - 1'b1;
                ST_BURST: begin
                    if (clear) st <= ST_IDLE;
                    if (done) left <= left - 1'b1;
                end
                ST_IDLE: begin
                    if (missed) begin
                        st   <= ST_BURST;
                        left <= BW'(WAKE_CNT);
                    end else if (take_rf) st <= ST_RF;
                    else if (acc_req)     st <= ST_ACC;
                end
                ST_RF:  if (done) st <= ST_IDLE;
                ST_ACC: if (!acc_req) st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign acc_gnt = (st == ST_ACC);
    assign ready   = (st == ST_IDLE) || (st == ST_ACC) || (st == ST_RF);
    assign ras_n   = strb.ras_n;
    assign cas_n   = strb.cas_n;

    p_gnt_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        acc_gnt |-> (ras_n && cas_n == 2'b11));

    p_urgent_wins_r7: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && urgent && !missed) |=> (st == ST_RF && !acc_gnt));

    p_start_when_free_r3: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy);

    p_miss_rewake_r9: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && missed) |=> !ready);

endmodule

// File: tb/test_dram_refresh_seq.sv
module test_dram_refresh_seq;

    localparam int CLK = 5;
    localparam int AW  = 10;
    localparam int NR  = 1 << AW;
    localparam int TH  = 4;
    localparam int NW  = 8;

    function automatic int cyc(int ns);
        int c;
        c = (ns + CLK - 1) / CLK;
        return (c < 1) ? 1 : c;
    endfunction

    localparam int E_ACT  = (cyc(50) > cyc(8)) ? cyc(50) : cyc(8);
    localparam int E_RP   = cyc(30);
    localparam int E_CSR  = cyc(6);
    localparam int E_WAKE = cyc(200);
    localparam int E_INT  = cyc(204800 / NR);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          rf_mode = 1'b0;
    logic          acc_req = 1'b1;
    logic          acc_gnt, ras_n, ready, urgent;
    logic [1:0]    cas_n;
    logic [AW-1:0] row_addr;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    dram_refresh_seq #(
        .CLK_NS(CLK), .ADDR_W(AW), .WINDOW_NS(204800), .WAKE_NS(200),
        .WAKE_CNT(NW), .RAS_NS(50), .RP_NS(30), .CSR_NS(6), .CHR_NS(8), .URG_TH(TH)
    ) i_dram_refresh_seq (
        .clk(clk), .rst(rst), .rf_mode(rf_mode), .acc_req(acc_req), .acc_gnt(acc_gnt),
        .ras_n(ras_n), .cas_n(cas_n), .row_addr(row_addr), .ready(ready), .urgent(urgent)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    typedef struct {bit ras; bit [1:0] cas; int addr;} exp_t;
    exp_t q[$];
    int  m_st;      // 0 pause, 1 burst, 2 idle, 3 granted, 4 refresh
    int  m_wait, m_left, m_pend, m_tick, m_row, m_cmode;
    bit  started = 0;

    always @(posedge clk) begin
        if (rst) begin
            q.delete();
            m_st = 0; m_wait = E_WAKE; m_left = 0; m_pend = 0; m_tick = 0; m_row = 0; m_cmode = 0;
            started = 1;
        end else begin
            bit tick, busy, done, st_go, clr, dc;
            tick = (m_tick == E_INT - 1);
            m_tick = tick ? 0 : m_tick + 1;
            busy = (q.size() != 0);
            done = (q.size() == 1);
            st_go = 0; clr = 0; dc = 0;
            case (m_st)
                0: if (m_wait <= 1) begin m_st = 1; m_left = NW; end else m_wait--;
                1: begin
                    if (!busy && m_left != 0) st_go = 1;
                    else if (!busy) begin m_st = 2; clr = 1; end
                    if (done) m_left--;
                end
                2: if (m_pend == NR) begin m_st = 1; m_left = NW; end
                   else if (m_pend >= TH || (m_pend != 0 && !acc_req)) begin st_go = 1; m_st = 4; end
                   else if (acc_req) m_st = 3;
                3: if (!acc_req) m_st = 2;
                4: if (done) begin m_st = 2; dc = 1; end
                default: ;
            endcase
            if (busy) void'(q.pop_front());
            if (done && m_cmode == 1) m_row = (m_row + 1) % NR;
            if (st_go) begin
                int su;
                m_cmode = rf_mode;
                su = (m_cmode == 1) ? 1 : E_CSR;
                for (int i = 0; i < su; i++)
                    q.push_back('{1'b1, (m_cmode == 1) ? 2'b11 : 2'b00, (m_cmode == 1) ? m_row : 0});
                for (int i = 0; i < E_ACT; i++)
                    q.push_back('{1'b0, (m_cmode == 1) ? 2'b11 : 2'b00, (m_cmode == 1) ? m_row : 0});
                for (int i = 0; i < E_RP; i++)
                    q.push_back('{1'b1, 2'b11, 0});
            end
            if (clr) m_pend = 0;
            else m_pend = m_pend + ((tick && m_pend < NR) ? 1 : 0) - (dc ? 1 : 0);
        end
    end

    // per-cycle comparison and directed monitors, away from the active edge
    bit prev_ras = 1, prev_ready = 0;
    int lead = 0, burst_falls = 0, ready_rises = 0, wraps = 0, last_row = -1;

    always @(negedge clk) begin
        if (started && !rst) begin
            chk("R3", "ras_n", ras_n, (q.size() != 0) ? q[0].ras : 1);
            chk("R4", "cas_n", cas_n, (q.size() != 0) ? q[0].cas : 3);
            chk("R5", "row_addr", row_addr, (q.size() != 0) ? q[0].addr : 0);
            chk("R8", "acc_gnt", acc_gnt, (m_st == 3) ? 1 : 0);
            chk("R2", "ready", ready, (m_st >= 2) ? 1 : 0);
            chk("R7", "urgent", urgent, (m_pend >= TH) ? 1 : 0);
            // R10: CAS lead before RAS falls in CAS-before-RAS cycles
            if (ras_n && cas_n == 2'b00) lead++;
            else if (!ras_n && prev_ras && cas_n == 2'b00) begin
                chk("R10", "cas lead cycles", lead, 2);
                lead = 0;
            end else if (ras_n) lead = 0;
            // R5: wrap of the row counter
            if (!ras_n && prev_ras && cas_n == 2'b11) begin
                if (last_row == NR - 1 && row_addr == 0) wraps++;
                last_row = row_addr;
            end
            // R2 / R9: pulses within each wake-up burst
            if (!ready && !ras_n && prev_ras) burst_falls++;
            if (ready && !prev_ready) begin
                ready_rises++;
                chk((ready_rises == 1) ? "R2" : "R9", "wake pulses", burst_falls, NW);
                burst_falls = 0;
            end
            prev_ras = ras_n;
            prev_ready = ready;
        end
    end

    task automatic summary;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

    initial begin
        bit [15:0] lfsr;
        lfsr = 16'hACE1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: quiet pause with the request held
        repeat (E_WAKE - 2) @(negedge clk);
        chk("R1", "ras_n in pause", ras_n, 1);
        chk("R1", "cas_n in pause", cas_n, 3);
        chk("R1", "ready in pause", ready, 0);
        chk("R1", "acc_gnt in pause", acc_gnt, 0);
        while (!ready) @(negedge clk);
        // R8, R7: hold the bus so debt builds up
        repeat (6 * E_INT) @(negedge clk);
        chk("R7", "urgent after long hold", urgent, 1);
        acc_req = 1'b0;
        repeat (400) @(negedge clk);
        chk("R6", "debt paid back", urgent, 0);
        // mixed traffic, both refresh styles
        for (int i = 0; i < 4000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[3:0] == 4'h0) acc_req = ~acc_req;
            if (lfsr[9:4] == 6'h00) rf_mode = ~rf_mode;
            @(negedge clk);
        end
        // R5: long row-address stretch to wrap the row counter
        acc_req = 1'b0;
        rf_mode = 1'b1;
        repeat (42500) @(negedge clk);
        chk("R5", "row counter wrapped", (wraps > 0) ? 1 : 0, 1);
        // R9: hold the bus past a full window
        rf_mode = 1'b0;
        acc_req = 1'b1;
        repeat (NR * E_INT + 200) @(negedge clk);
        chk("R9", "still granted before release", acc_gnt, 1);
        acc_req = 1'b0;
        repeat (2) @(negedge clk);
        chk("R9", "ready dropped for re-wake", ready, 0);
        repeat (400) @(negedge clk);
        chk("R9", "ready rises after re-wake", ready_rises, 2);
        chk("R6", "debt cleared after re-wake", urgent, 0);
        summary();
    end

endmodule